// File: doc/BRIEF.md
# Stop-Mode Oscillation Stabilization Timer

This block decides how long the CPU clock stays off after the core leaves stop mode. An 8-bit prescaler clocks an 8-bit timer. The CPU clock enable returns only when the timer underflows. Until then the oscillator is given time to settle. A stop request either loads fixed start values into the two counters or leaves the values software wrote there. A control input selects which. A wait request only gates the CPU clock, and an enabled interrupt ends it at once.

After reset the block runs a stabilization count on the divide-by-16 tick of the main oscillator. A count started by a stop uses the tick source that was in use before the stop. All logic runs on one clock. Each count source arrives as a one-cycle tick enable.

Top module: `stop_stab_timer`

## Requirements
- R1: While reset is asserted, and after it is released, `cpu_clk_en_o` is 0. The release count starts with the prescaler at 0xFF and the timer at 0x01. It uses `tick_div16_i`, so the clock enable returns after 512 such ticks.
- R2: A stop request while running with `preload_off_i` = 0 sets the prescaler and its reload value to 0xFF and the timer to 0x01. After the wake-up the count lasts 512 ticks.
- R3: A stop request with `preload_off_i` = 1 leaves the counters untouched. The count lasts (P+1)*(T+1) ticks, where P is the prescaler value and T is the timer value. This holds down to P = T = 0, which gives one tick.
- R4: A count that follows a stop advances only on `tick_run_i`. The count after reset advances only on `tick_div16_i`. Ticks on the other source have no effect.
- R5: A stop request drops `cpu_clk_en_o` on the next cycle. The block then stays stopped with frozen counters until `irq_i` = 1 arrives with `irq_dis_i` = 0. An interrupt that arrives while `irq_dis_i` = 1 does nothing.
- R6: A wait request drops `cpu_clk_en_o` on the next cycle. An enabled interrupt raises it on the cycle after, with no count. A masked interrupt does nothing.
- R7: During a stabilization count, stop, wait and interrupt inputs are ignored.
- R8: Software writes set the prescaler and its reload value (`pre_wr_i`) or the timer (`tmr_wr_i`). They take effect only while running without a stop or wait request in the same cycle. At other times they are ignored.
- R9: When stop and wait are requested in the same cycle, the stop wins.
- R10: `cpu_clk_en_o` rises on the cycle after the tick on which the prescaler and the timer are both 0. After that tick the prescaler is reloaded and the timer stays at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset |
| stp_i | input | 1 | Stop request strobe |
| wit_i | input | 1 | Wait request strobe |
| irq_i | input | 1 | Interrupt request |
| irq_dis_i | input | 1 | Interrupt disable flag (1 = masked) |
| preload_off_i | input | 1 | 1 = no preload on stop |
| tick_div16_i | input | 1 | Count tick at oscillator/16 (reset source) |
| tick_run_i | input | 1 | Count tick of the source in use before stop |
| pre_wr_i | input | 1 | Prescaler write strobe |
| pre_wdata_i | input | PRE_W | Prescaler write value |
| tmr_wr_i | input | 1 | Timer write strobe |
| tmr_wdata_i | input | TMR_W | Timer write value |
| cpu_clk_en_o | output | 1 | CPU clock enable |

## Verification
The bench builds the block with its default 8-bit prescaler and timer, so the fixed 0xFF/0x01 preload gives the real 512-tick wait. This allows a full reset count on a tick that fires every 16 cycles. Software writes of small values, including zero in both counters, bring the shortest waits and the reload path within reach in a few cycles. A behavioural model that tracks only a remaining-tick total is compared with the clock enable on every cycle.

// File: rtl/stop_stab_timer.sv
module stop_stab_timer #(
  parameter int PRE_W    = 8,
  parameter int TMR_W    = 8,
  parameter int PRE_INIT = 255,
  parameter int TMR_INIT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stp_i,
  input  logic             wit_i,
  input  logic             irq_i,
  input  logic             irq_dis_i,
  input  logic             preload_off_i,
  input  logic             tick_div16_i,
  input  logic             tick_run_i,
  input  logic             pre_wr_i,
  input  logic [PRE_W-1:0] pre_wdata_i,
  input  logic             tmr_wr_i,
  input  logic [TMR_W-1:0] tmr_wdata_i,
  output logic             cpu_clk_en_o
);
  localparam logic [PRE_W-1:0] PRE_LD = PRE_W'(PRE_INIT);
  localparam logic [TMR_W-1:0] TMR_LD = TMR_W'(TMR_INIT);

  typedef enum logic [1:0] {S_RUN, S_STOP, S_WAIT, S_STAB} st_t;

  st_t              st;
  logic [PRE_W-1:0] pre_cnt, pre_rld;
  logic [TMR_W-1:0] tmr_cnt;
  logic             rst_src;

  wire wake   = irq_i & ~irq_dis_i;
  wire tick   = rst_src ? tick_div16_i : tick_run_i;
  wire pre_uf = (pre_cnt == '0);
  wire done   = tick & pre_uf & (tmr_cnt == '0);
  wire sw_ok  = (st == S_RUN) & ~stp_i & ~wit_i;

  assign cpu_clk_en_o = (st == S_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_STAB;
      pre_cnt <= PRE_LD;
      pre_rld <= PRE_LD;
      tmr_cnt <= TMR_LD;
      rst_src <= 1'b1;
    end else begin
      unique case (st)
        S_RUN: begin
          if (stp_i) begin
            st <= S_STOP;
            if (!preload_off_i) begin
              pre_cnt <= PRE_LD;
              pre_rld <= PRE_LD;
              tmr_cnt <= TMR_LD;
            end
          end else if (wit_i) begin
            st <= S_WAIT;
          end else begin
            if (pre_wr_i) begin
              pre_cnt <= pre_wdata_i;
              pre_rld <= pre_wdata_i;
            end
            if (tmr_wr_i) tmr_cnt <= tmr_wdata_i;
          end
        end
        S_STOP: if (wake) st <= S_STAB;
        S_WAIT: if (wake) st <= S_RUN;
        S_STAB: begin
          if (tick) begin
            if (pre_uf) begin
              pre_cnt <= pre_rld;
              if (tmr_cnt == '0) begin
                st      <= S_RUN;
                rst_src <= 1'b0;
              end else begin
                tmr_cnt <= tmr_cnt - 1'b1;
              end
            end else begin
              pre_cnt <= pre_cnt - 1'b1;
            end
          end
        end
        default: st <= S_STAB;
      endcase
    end
  end

  p_stop_gates_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && stp_i) |=> !cpu_clk_en_o);

  p_stop_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STOP && !wake) |=> (st == S_STOP && $stable(pre_cnt) && $stable(tmr_cnt)));

  p_preload_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && stp_i && !preload_off_i) |=> (pre_cnt == PRE_LD && tmr_cnt == TMR_LD));

  p_no_preload_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_clk_en_o && stp_i && preload_off_i) |=> ($stable(pre_cnt) && $stable(tmr_cnt)));

  p_wake_wait_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_WAIT && wake) |=> cpu_clk_en_o);

  p_rise_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_clk_en_o) |-> ($past(st) == S_WAIT ||
      ($past(st) == S_STAB && $past(pre_cnt) == '0 && $past(tmr_cnt) == '0)));

  p_stab_ignores_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_STAB && !done) |=> (st == S_STAB));
endmodule

// File: tb/stop_stab_timer_tb.sv
module stop_stab_timer_tb;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0;
  logic stp = 0, wit = 0, irq = 0, irq_dis = 0, poff = 0;
  logic t16 = 0, trun = 0, pwr = 0, twr = 0;
  logic [7:0] pdat = 0, tdat = 0;
  logic en;

  int checks = 0, fails = 0, cyc = 0, run_div = 1;
  bit finished = 0;
  string phase = "R1";

  // reference model: 0 run, 1 stop, 2 wait, 3 stabilizing
  int mst, rem, m_pre, m_tmr;
  bit m_rsrc;

  always #(CLK_P/2) clk = ~clk;

  stop_stab_timer u_dut (
    .clk(clk), .rst_n(rst_n), .stp_i(stp), .wit_i(wit), .irq_i(irq),
    .irq_dis_i(irq_dis), .preload_off_i(poff), .tick_div16_i(t16),
    .tick_run_i(trun), .pre_wr_i(pwr), .pre_wdata_i(pdat),
    .tmr_wr_i(twr), .tmr_wdata_i(tdat), .cpu_clk_en_o(en)
  );

  always @(negedge clk) begin
    cyc++;
    t16  <= (cyc % 16 == 0);
    trun <= (cyc % run_div == 0);
  end

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mst = 3; m_pre = 255; m_tmr = 1; rem = 512; m_rsrc = 1;
    end else begin
      case (mst)
        0: if (stp) begin
             mst = 1;
             if (!poff) begin m_pre = 255; m_tmr = 1; end
             rem = (m_pre + 1) * (m_tmr + 1);
           end else if (wit) mst = 2;
           else begin
             if (pwr) m_pre = pdat;
             if (twr) m_tmr = tdat;
           end
        1: if (irq && !irq_dis) mst = 3;
        2: if (irq && !irq_dis) mst = 0;
        default: if (m_rsrc ? t16 : trun) begin
             rem--;
             if (rem == 0) begin mst = 0; m_rsrc = 0; m_tmr = 0; end
           end
      endcase
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: cpu_clk_en actual=%b expected=%b at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (!finished) chk(en, (mst == 0), phase);

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_en();
    int k = 0;
    while (!en && k < 20000) begin step(1); k++; end
    if (!en) begin
      fails++;
      $display("FAIL %s: watchdog actual=no_release expected=release", phase);
    end
    step(2);
  endtask

  task automatic sw_write(input int p, input int t);
    pdat = 8'(p); tdat = 8'(t); pwr = 1; twr = 1; step(1); pwr = 0; twr = 0;
  endtask

  task automatic do_stop(input bit off);
    poff = off; stp = 1; step(1); stp = 0; step(5);
  endtask

  task automatic wake_irq();
    irq_dis = 0; irq = 1; step(1); irq = 0;
  endtask

  initial begin
    step(3);
    chk(en, 1'b0, "R1 under reset");
    rst_n = 1;
    step(1);
    chk(en, 1'b0, "R1 after release");
    phase = "R1/R4 reset count";
    wait_en();

    phase = "R2/R5 preload stop";
    run_div = 2;
    do_stop(0);
    step(40);
    irq_dis = 1; irq = 1; step(3); irq = 0; step(3);
    phase = "R5 masked irq in stop";
    chk(en, 1'b0, "R5 masked irq");
    wake_irq();
    phase = "R7 ignore during count";
    step(4);
    stp = 1; wit = 1; irq = 1; step(2); stp = 0; wit = 0; irq = 0;
    phase = "R2/R10 preload count";
    wait_en();

    phase = "R3/R8 software values";
    run_div = 1;
    sw_write(3, 2);
    do_stop(1);
    wake_irq();
    wait_en();

    phase = "R3 zero values";
    sw_write(0, 0);
    do_stop(1);
    wake_irq();
    wait_en();

    phase = "R3/R10 reload reuse";
    sw_write(5, 1);
    do_stop(1); wake_irq(); wait_en();
    do_stop(1); wake_irq(); wait_en();

    phase = "R4 run source only";
    run_div = 5;
    sw_write(20, 2);
    do_stop(1); wake_irq(); wait_en();
    run_div = 1;

    phase = "R6 wait";
    wit = 1; step(1); wit = 0;
    step(1);
    chk(en, 1'b0, "R6 wait gates");
    irq_dis = 1; irq = 1; step(2); irq = 0;
    chk(en, 1'b0, "R6 masked irq");
    wake_irq();
    step(1);
    chk(en, 1'b1, "R6 enabled irq wakes");

    phase = "R9 stop over wait";
    sw_write(2, 1);
    poff = 1; stp = 1; wit = 1; step(1); stp = 0; wit = 0;
    step(3);
    phase = "R8 write in stop ignored";
    pdat = 0; tdat = 0; pwr = 1; twr = 1; step(1); pwr = 0; twr = 0;
    wake_irq();
    step(1);
    chk(en, 1'b0, "R9 stop wins");
    wait_en();

    phase = "R8 write with stop ignored";
    pdat = 9; tdat = 9; pwr = 1; twr = 1; poff = 1; stp = 1; step(1);
    pwr = 0; twr = 0; stp = 0;
    wake_irq(); wait_en();

    phase = "R1 reset in stop";
    do_stop(0);
    rst_n = 0; step(2); rst_n = 1;
    step(1);
    chk(en, 1'b0, "R1 reset restarts count");
    wait_en();

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule